// File: doc/BRIEF.md
# Runtime-Programmable Parallel CRC Engine

This block computes a cyclic redundancy check over a message while taking DATA_W message bits in each clock. Each accepted word moves the CRC_W-bit state forward by DATA_W serial divider steps in one cycle. The step is a product over GF(2) with a CRC_W-by-CRC_W enable matrix, equal to the single-step matrix raised to the power DATA_W. The generator polynomial is not fixed when the design is built. Software-side logic writes it through a load port. The block then builds the power matrix in hardware, one power per cycle, and flags itself busy until the matrix is ready. DATA_W must divide CRC_W and may be smaller than it.

Two feed modes are supported. In augmented mode the caller sends the message and then CRC_W/DATA_W all-zero words, and the state ends holding the remainder. In direct mode each word is folded into the top of the state before the matrix is applied. No zero words are needed, and the final state is the same remainder. A clear input zeroes the state and keeps the matrix.

Top module: `crc_matrix_engine`

## Requirements
- R1: While rst is high and on the first cycle after it, crc_out is all zero and poly_busy is low.
- R2: A poly_load seen with poly_busy low raises poly_busy on the next cycle. poly_busy then stays high for exactly DATA_W-1 cycles. poly_in bit j is the coefficient of x^j, and the leading x^CRC_W term is implied.
- R3: A poly_load that arrives while poly_busy is high is ignored. The matrix stays the one built from the earlier load.
- R4: Augmented mode (mode_direct=0): data_in bit DATA_W-1 is the earliest message bit. After the message words and then CRC_W/DATA_W zero words, crc_out equals the remainder of message·x^CRC_W divided by the generator. crc_out bit CRC_W-1 is the highest remainder coefficient.
- R5: Direct mode (mode_direct=1): after only the message words, crc_out equals the same remainder that R4 gives.
- R6: data_valid has no effect on crc_out while poly_busy is high.
- R7: With data_valid and clr both low, crc_out keeps its value.
- R8: clr makes crc_out zero on the next cycle and takes priority over data_valid. The matrix is kept, so a message sent after the clear is checked with the last loaded polynomial.
- R9: Results are the same for every DATA_W that divides CRC_W, including DATA_W < CRC_W.
- R10: With generator 0x1021, zero start state and the ASCII message "123456789", the result is 0x31C3 in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poly_load | input | 1 | Accept poly_in and start building the matrix |
| poly_in | input | CRC_W | Generator coefficients, leading term excluded |
| poly_busy | output | 1 | Matrix build in progress; data and loads are ignored |
| data_valid | input | 1 | data_in holds a message word |
| data_in | input | DATA_W | Message word, earliest bit in the MSB |
| mode_direct | input | 1 | 0 = augmented feed, 1 = direct feed |
| clr | input | 1 | Zero the state |
| crc_out | output | CRC_W | Registered CRC state |

## Verification
The hardest states to reach are the ones where a second load or data words arrive during the matrix build. The bench asserts poly_load again in the cycle right after an accepted load, and holds data_valid high with all-ones data through every busy cycle. A later message result then shows that neither input left a trace. A bit-serial model in the bench produces the expected remainder from random-looking messages. Three engines with data widths 4, 8 and 16 run the same table.

// File: rtl/crcm_pkg.sv
package crcm_pkg;

  typedef enum logic {
    CRC_MODE_AUG    = 1'b0,
    CRC_MODE_DIRECT = 1'b1
  } crc_mode_e;

endpackage

// File: rtl/crcm_matvec.sv
// GF(2) matrix times vector: column j of mat is added when vec[j] is set.
module crcm_matvec #(
  parameter int N = 16
) (
  input  logic [N-1:0][N-1:0] mat,
  input  logic [N-1:0]        vec,
  output logic [N-1:0]        res
);

  always_comb begin
    res = '0;
    for (int j = 0; j < N; j++) begin
      res = res ^ (mat[j] & {N{vec[j]}});
    end
  end

endmodule

// File: rtl/crcm_pow_builder.sv
// Builds A^K column by column, one power per cycle, after a polynomial load.
module crcm_pow_builder #(
  parameter int N = 16,
  parameter int K = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [N-1:0]       poly,
  output logic               busy,
  output logic [N-1:0][N-1:0] mat
);

  localparam int CNT_W = $clog2(K + 1);

  logic [N-1:0]              poly_q;
  logic [CNT_W-1:0]          pw;
  logic [N-1:0][N-1:0]       step_mat;
  logic [N-1:0][N-1:0]       next_mat;
  logic [N-1:0]              new_col;

  // Single-step matrix: columns below the top move a bit up one place,
  // the top column carries the feedback taps.
  for (genvar j = 0; j < N; j++) begin : g_step
    if (j == N - 1) begin : g_fb
      assign step_mat[j] = poly;
    end else begin : g_sh
      assign step_mat[j] = N'(1) << (j + 1);
    end
  end

  // A^(k+1) = A^k * A : columns move down one slot, new top column = A^k * p
  crcm_matvec #(.N(N)) u_fb_mv (
    .mat (mat),
    .vec (poly_q),
    .res (new_col)
  );

  for (genvar j = 0; j < N; j++) begin : g_next
    if (j == N - 1) begin : g_top
      assign next_mat[j] = new_col;
    end else begin : g_low
      assign next_mat[j] = mat[j+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mat    <= '0;
      poly_q <= '0;
      pw     <= '0;
      busy   <= 1'b0;
    end else if (load && !busy) begin
      mat    <= step_mat;
      poly_q <= poly;
      pw     <= CNT_W'(1);
      busy   <= (K > 1);
    end else if (busy) begin
      mat    <= next_mat;
      pw     <= pw + 1'b1;
      busy   <= (pw != CNT_W'(K - 1));
    end
  end

endmodule

// File: rtl/crc_matrix_engine.sv
module crc_matrix_engine #(
  parameter int CRC_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poly_load,
  input  logic [CRC_W-1:0]  poly_in,
  output logic              poly_busy,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_in,
  input  logic              mode_direct,
  input  logic              clr,
  output logic [CRC_W-1:0]  crc_out
);
  import crcm_pkg::*;

  localparam int PAD_W = CRC_W - DATA_W;

  crc_mode_e                  mode;
  logic                       busy;
  logic [CRC_W-1:0][CRC_W-1:0] pow_mat;
  logic [CRC_W-1:0]           state_q;
  logic [CRC_W-1:0]           data_hi;
  logic [CRC_W-1:0]           data_lo;
  logic [CRC_W-1:0]           mv_in;
  logic [CRC_W-1:0]           mv_out;
  logic [CRC_W-1:0]           state_d;

  assign mode = crc_mode_e'(mode_direct);

  crcm_pow_builder #(.N(CRC_W), .K(DATA_W)) u_builder (
    .clk  (clk),
    .rst  (rst),
    .load (poly_load),
    .poly (poly_in),
    .busy (busy),
    .mat  (pow_mat)
  );

  assign data_lo = CRC_W'(data_in);
  assign data_hi = data_lo << PAD_W;

  always_comb begin
    mv_in = (mode == CRC_MODE_DIRECT) ? (state_q ^ data_hi) : state_q;
  end

  crcm_matvec #(.N(CRC_W)) u_data_mv (
    .mat (pow_mat),
    .vec (mv_in),
    .res (mv_out)
  );

  always_comb begin
    state_d = (mode == CRC_MODE_DIRECT) ? mv_out : (mv_out ^ data_lo);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q <= '0;
    end else if (data_valid && !busy) begin
      state_q <= state_d;
    end
  end

  assign crc_out   = state_q;
  assign poly_busy = busy;

endmodule

// File: rtl/crcm_checker.sv
module crcm_checker #(
  parameter int CRC_W  = 16,
  parameter int DATA_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             poly_load,
  input logic             poly_busy,
  input logic             data_valid,
  input logic             clr,
  input logic [CRC_W-1:0] crc_out
);

  int bcnt;

  always_ff @(posedge clk) begin
    if (rst) bcnt <= 0;
    else     bcnt <= poly_busy ? bcnt + 1 : 0;
  end

  p_load_starts_build_r2: assert property (@(posedge clk) disable iff (rst)
    (poly_load && !poly_busy) |=> (poly_busy == (DATA_W > 1)));

  p_busy_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    poly_busy |-> (bcnt < DATA_W - 1));

  p_busy_blocks_data_r6: assert property (@(posedge clk) disable iff (rst)
    (poly_busy && !clr) |=> $stable(crc_out));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!data_valid && !clr) |=> $stable(crc_out));

  p_clr_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc_out == '0));

endmodule

bind crc_matrix_engine crcm_checker #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .poly_load  (poly_load),
  .poly_busy  (poly_busy),
  .data_valid (data_valid),
  .clr        (clr),
  .crc_out    (crc_out)
);

// File: tb/crcm_lane.sv
// One engine instance with its own stimulus; reports counts to the bench top.
module crcm_lane #(
  parameter int M = 16,
  parameter int W = 8
) (
  input  logic clk,
  output int   n_chk,
  output int   n_bad,
  output logic done
);

  localparam int NVEC = 4;
  localparam logic [NVEC-1:0][15:0] POLY_TBL = {16'hA097, 16'h3D65, 16'h1021, 16'h8005};
  localparam logic [NVEC-1:0][63:0] MSG_TBL  = {64'h0123456789ABCDEF, 64'hFFFF0000A5A5C3C3,
                                                64'h8000000000000001, 64'hDEADBEEF13579BDF};

  logic         rst, poly_load, poly_busy, data_valid, mode_direct, clr;
  logic [M-1:0] poly_in, crc_out;
  logic [W-1:0] data_in;

  crc_matrix_engine #(.CRC_W(M), .DATA_W(W)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .poly_load   (poly_load),
    .poly_in     (poly_in),
    .poly_busy   (poly_busy),
    .data_valid  (data_valid),
    .data_in     (data_in),
    .mode_direct (mode_direct),
    .clr         (clr),
    .crc_out     (crc_out)
  );

  function automatic logic [M-1:0] ref_crc(input logic [M-1:0] p, input logic [127:0] bits,
                                           input int nb, input bit direct);
    logic [M-1:0] s;
    logic         fb;
    s = '0;
    for (int i = nb - 1; i >= 0; i--) begin
      if (direct) begin
        fb = s[M-1] ^ bits[i];
        s  = {s[M-2:0], 1'b0} ^ (fb ? p : '0);
      end else begin
        fb = s[M-1];
        s  = {s[M-2:0], bits[i]} ^ (fb ? p : '0);
      end
    end
    if (!direct) begin
      for (int i = 0; i < M; i++) begin
        fb = s[M-1];
        s  = {s[M-2:0], 1'b0} ^ (fb ? p : '0);
      end
    end
    return s;
  endfunction

  task automatic chk(input logic [M-1:0] act, input logic [M-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (M=%0d W=%0d): actual %h expected %h", tag, M, W, act, exp);
    end
  endtask

  task automatic load_poly(input logic [M-1:0] p, output int cycles);
    poly_in   = p;
    poly_load = 1'b1;
    @(negedge clk);
    poly_load = 1'b0;
    cycles    = 0;
    while (poly_busy) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic clear_state();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic feed(input logic [127:0] bits, input int nb, input bit direct, input bit zeros);
    mode_direct = direct;
    for (int w = 0; w < nb / W; w++) begin
      data_in    = bits[nb-1-w*W -: W];
      data_valid = 1'b1;
      @(negedge clk);
    end
    if (zeros) begin
      for (int w = 0; w < M / W; w++) begin
        data_in    = '0;
        data_valid = 1'b1;
        @(negedge clk);
      end
    end
    data_valid = 1'b0;
  endtask

  initial begin
    int            cyc;
    logic [M-1:0]  hold_v;
    logic [M-1:0]  p1;
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst = 1'b1; poly_load = 1'b0; poly_in = '0; data_valid = 1'b0;
    data_in = '0; mode_direct = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(crc_out, '0, "R1 reset state");
    chk(M'(poly_busy), '0, "R1 reset busy");
    rst = 1'b0;
    @(negedge clk);
    chk(crc_out, '0, "R1 after release");

    // Table walk: each polynomial, message in both modes
    for (int e = 0; e < NVEC; e++) begin
      load_poly(M'(POLY_TBL[e]), cyc);
      chk(M'(cyc), M'(W - 1), "R2 busy length");
      clear_state();
      feed(128'(MSG_TBL[e]), 64, 1'b0, 1'b1);
      chk(crc_out, ref_crc(M'(POLY_TBL[e]), 128'(MSG_TBL[e]), 64, 1'b0), "R4/R9 augmented");
      clear_state();
      feed(128'(MSG_TBL[e]), 64, 1'b1, 1'b0);
      chk(crc_out, ref_crc(M'(POLY_TBL[e]), 128'(MSG_TBL[e]), 64, 1'b1), "R5/R9 direct");
      chk(crc_out, ref_crc(M'(POLY_TBL[e]), 128'(MSG_TBL[e]), 64, 1'b0), "R5 modes agree");
    end

    // R6: data words held valid through the whole build
    clear_state();
    poly_in = M'(POLY_TBL[0]); poly_load = 1'b1; mode_direct = 1'b0;
    @(negedge clk);
    poly_load = 1'b0; data_in = '1; data_valid = 1'b1;
    while (poly_busy) @(negedge clk);
    data_valid = 1'b0;
    chk(crc_out, '0, "R6 data ignored while busy");

    // R3: second load one cycle after an accepted load
    p1 = M'(POLY_TBL[1]);
    poly_in = p1; poly_load = 1'b1;
    @(negedge clk);
    poly_in = M'(POLY_TBL[2]);
    @(negedge clk);
    poly_load = 1'b0;
    while (poly_busy) @(negedge clk);
    clear_state();
    feed(128'(MSG_TBL[0]), 64, 1'b0, 1'b1);
    chk(crc_out, ref_crc(p1, 128'(MSG_TBL[0]), 64, 1'b0), "R3 load while busy ignored");

    // R7: state holds while idle
    clear_state();
    feed(128'(16'hBEEF), 16, 1'b1, 1'b0);
    hold_v = crc_out;
    repeat (3) @(negedge clk);
    chk(crc_out, hold_v, "R7 hold when idle");

    // R8: clear beats valid, matrix kept
    clr = 1'b1; data_valid = 1'b1; data_in = '1;
    @(negedge clk);
    clr = 1'b0; data_valid = 1'b0;
    chk(crc_out, '0, "R8 clear over valid");
    feed(128'(MSG_TBL[1]), 64, 1'b0, 1'b1);
    chk(crc_out, ref_crc(p1, 128'(MSG_TBL[1]), 64, 1'b0), "R8 matrix kept");

    // R10: known check value
    if ((72 % W) == 0 && M == 16) begin
      load_poly(M'(16'h1021), cyc);
      clear_state();
      feed(128'h313233343536373839, 72, 1'b1, 1'b0);
      chk(crc_out, M'(16'h31C3), "R10 direct known value");
      clear_state();
      feed(128'h313233343536373839, 72, 1'b0, 1'b1);
      chk(crc_out, M'(16'h31C3), "R10 augmented known value");
    end
    done = 1'b1;
  end

endmodule

// File: tb/crc_matrix_engine_tb.sv
module crc_matrix_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int   c4, f4, c8, f8, c16, f16;
  logic d4, d8, d16;

  crcm_lane #(.M(16), .W(4))  u_lane_w4  (.clk(clk), .n_chk(c4),  .n_bad(f4),  .done(d4));
  crcm_lane #(.M(16), .W(8))  u_lane_w8  (.clk(clk), .n_chk(c8),  .n_bad(f8),  .done(d8));
  crcm_lane #(.M(16), .W(16)) u_lane_w16 (.clk(clk), .n_chk(c16), .n_bad(f16), .done(d16));

  initial begin
    int cyc;
    int total;
    int bad;
    cyc = 0;
    while (!(d4 === 1'b1 && d8 === 1'b1 && d16 === 1'b1) && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    @(negedge clk);
    total = c4 + c8 + c16;
    bad   = f4 + f8 + f16;
    if (cyc >= WATCHDOG) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual timeout after %0d cycles expected completion", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", total, bad);
    $finish;
  end

endmodule